// File: doc/BRIEF.md
# I2C Arbitration Loss and Bus-Condition Monitor

This block sits next to a bit-level I2C port. It watches the SCL and SDA lines and compares them with what the local port is trying to put on the bus. The local port may be sending a data bit of value one, setting up a repeated start, or releasing SDA for a stop. Both lines are synchronised to the system clock. From those samples the block finds start and stop conditions and keeps a bus-busy level. A bus time-out input also clears bus-busy.

The block also judges arbitration. It tells the local transmitter when another driver has won the bus, and it reports which of four collision situations caused the loss. The local port uses the loss pulse to release the lines. It can use the case code to decide how to recover.

All event outputs are single-cycle pulses. There are no data streams in this block, so every pin is a plain level or pulse and no valid/ready rules apply.

Top module: `i2c_arb_monitor`

## Requirements
- R1: A start condition is SDA going from 1 to 0 in the synchronised samples while SCL is 1 in both samples. Each start condition gives exactly one single-cycle pulse on `start_seen`.
- R2: A stop condition is SDA going from 0 to 1 while SCL stays 1. Each stop condition gives exactly one single-cycle pulse on `stop_seen`. A start pulse and a stop pulse never occur in the same cycle.
- R3: `bus_busy` is 0 after reset. It becomes 1 with a start pulse and returns to 0 with a stop pulse.
- R4: A one-cycle pulse on `bus_timeout` clears `bus_busy` without producing a stop pulse.
- R5: Case code 0 (data collision): a loss is reported when the local side sends a 1 (`tx_one`) or is setting up a repeated start (`tx_rstart`) and SDA reads 0 at a rising edge of SCL.
- R6: Case code 1 (start collision): a loss is reported when the local side sends a 1 and another device makes a start condition during that SCL-high phase. This loss is reported in the same cycle as the start pulse.
- R7: Case code 2 (clock stolen): while `master_mode` is 1, a loss is reported when the local side is setting up a repeated start and SCL falls while SDA is still 1. When `master_mode` is 0 this situation reports nothing.
- R8: Case code 3 (stop blocked): while `master_mode` is 1, a loss is reported when the local side is trying to send a stop and SCL falls while SDA is 0. When `master_mode` is 0 this situation reports nothing.
- R9: `arb_lost` is never raised unless `tx_active` was 1 when the collision was detected. A collision while `tx_active` is 0 has no effect on any output.
- R10: `arb_case` holds the 2-bit case code given in R5 to R8. It is valid in the cycle in which `arb_lost` is 1.
- R11: A bit on which the local side sends 0 never causes a loss, whatever SDA reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_line | input | 1 | Raw SCL line level (asynchronous) |
| sda_line | input | 1 | Raw SDA line level (asynchronous) |
| tx_active | input | 1 | Local transmitter is driving the bus |
| master_mode | input | 1 | Local device currently acts as master |
| tx_one | input | 1 | Local data bit being sent is 1 (SDA released) |
| tx_rstart | input | 1 | Local port is setting up a repeated start |
| tx_stop | input | 1 | Local port is attempting a stop |
| bus_timeout | input | 1 | Bus time-out pulse; clears busy |
| start_seen | output | 1 | One-cycle pulse per start condition |
| stop_seen | output | 1 | One-cycle pulse per stop condition |
| bus_busy | output | 1 | Bus is owned by some master |
| arb_lost | output | 1 | One-cycle arbitration-loss pulse |
| arb_case | output | 2 | Cause of the loss, valid with `arb_lost` |

## Verification
The data-bit collision is swept over all combinations of the local bit, the other driver's bit and `tx_active`. The expected loss is computed as the product of the local one, the other zero and the active flag. This sweep separates a correct wired-AND judgement from one that also fires on a local 0 or ignores `tx_active`.

Each of the three framing collisions is then swept over `master_mode` and `tx_active`. This shows that the two master-only cases stay silent for a slave. It also shows that every case sets its own code.

Plain start, stop and time-out sequences show that busy tracking follows the conditions. They also show that a time-out clears busy without faking a stop.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
  typedef enum logic [1:0] {
    CASE_DATA   = 2'd0,
    CASE_START  = 2'd1,
    CASE_CLKSTL = 2'd2,
    CASE_STOPBK = 2'd3
  } arb_case_e;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else if (STAGES == 1) chain <= raw_in[g];
      else chain <= {chain[STAGES-2:0], raw_in[g]};
    end
    assign sync_out[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/bus_cond.sv
module bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  input  logic bus_timeout,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev,
  output logic busy
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= 1'b0;
    else if (bus_timeout || stop_ev) busy <= 1'b0;
    else if (start_ev) busy <= 1'b1;
  end
endmodule

// File: rtl/arb_judge.sv
module arb_judge
  import i2c_arb_pkg::*;
(
  input  logic      scl_rise,
  input  logic      scl_fall,
  input  logic      start_ev,
  input  logic      sda_s,
  input  logic      tx_active,
  input  logic      master_mode,
  input  logic      tx_one,
  input  logic      tx_rstart,
  input  logic      tx_stop,
  output logic      lost,
  output arb_case_e why
);
  logic hit_data, hit_start, hit_clk, hit_stop;

  assign hit_data  = scl_rise & ~sda_s & (tx_one | tx_rstart);
  assign hit_start = start_ev & tx_one & ~tx_rstart;
  assign hit_clk   = master_mode & scl_fall & tx_rstart & sda_s;
  assign hit_stop  = master_mode & scl_fall & tx_stop & ~sda_s & ~tx_rstart;

  always_comb begin
    lost = tx_active & (hit_data | hit_start | hit_clk | hit_stop);
    if (hit_start)     why = CASE_START;
    else if (hit_clk)  why = CASE_CLKSTL;
    else if (hit_stop) why = CASE_STOPBK;
    else               why = CASE_DATA;
  end
endmodule

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor
  import i2c_arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_line,
  input  logic       sda_line,
  input  logic       tx_active,
  input  logic       master_mode,
  input  logic       tx_one,
  input  logic       tx_rstart,
  input  logic       tx_stop,
  input  logic       bus_timeout,
  output logic       start_seen,
  output logic       stop_seen,
  output logic       bus_busy,
  output logic       arb_lost,
  output logic [1:0] arb_case
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] lines_s;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic lost_d;
  arb_case_e why_d;

  line_sync #(.STAGES(SYNC_STAGES), .WIDTH(NLINES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .raw_in({scl_line, sda_line}),
    .sync_out(lines_s)
  );

  bus_cond u_cond (
    .clk(clk), .rst_n(rst_n),
    .scl_s(lines_s[1]), .sda_s(lines_s[0]),
    .bus_timeout(bus_timeout),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .busy(bus_busy)
  );

  arb_judge u_judge (
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev),
    .sda_s(lines_s[0]),
    .tx_active(tx_active), .master_mode(master_mode),
    .tx_one(tx_one), .tx_rstart(tx_rstart), .tx_stop(tx_stop),
    .lost(lost_d), .why(why_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_seen <= 1'b0;
      stop_seen  <= 1'b0;
      arb_lost   <= 1'b0;
      arb_case   <= 2'd0;
    end else begin
      start_seen <= start_ev;
      stop_seen  <= stop_ev;
      arb_lost   <= lost_d;
      arb_case   <= why_d;
    end
  end
endmodule

// File: rtl/i2c_arb_monitor_chk.sv
module i2c_arb_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_active,
  input logic       master_mode,
  input logic       bus_timeout,
  input logic       start_seen,
  input logic       stop_seen,
  input logic       bus_busy,
  input logic       arb_lost,
  input logic [1:0] arb_case
);
  // R1
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> !start_seen);
  // R2
  start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_seen && stop_seen));
  // R3
  stop_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |-> !bus_busy);
  // R4
  timeout_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_timeout |=> !bus_busy);
  // R9
  lost_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> $past(tx_active));
  // R6
  start_case_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && arb_case == 2'd1) |-> start_seen);
  // R7
  master_cases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && arb_case[1]) |-> $past(master_mode));
endmodule

bind i2c_arb_monitor i2c_arb_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .master_mode(master_mode),
  .bus_timeout(bus_timeout), .start_seen(start_seen), .stop_seen(stop_seen),
  .bus_busy(bus_busy), .arb_lost(arb_lost), .arb_case(arb_case)
);

// File: tb/sim_i2c_arb_monitor.sv
`timescale 1ns/1ps
module sim_i2c_arb_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_line = 1'b1, sda_line = 1'b1;
  logic tx_active = 1'b0, master_mode = 1'b0;
  logic tx_one = 1'b0, tx_rstart = 1'b0, tx_stop = 1'b0, bus_timeout = 1'b0;
  logic start_seen, stop_seen, bus_busy, arb_lost;
  logic [1:0] arb_case;

  int checks = 0, failures = 0;
  int n_start = 0, n_stop = 0, n_arb = 0;
  logic [1:0] last_case = 2'd0;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_arb_monitor u0 (
    .clk(clk), .rst_n(rst_n), .scl_line(scl_line), .sda_line(sda_line),
    .tx_active(tx_active), .master_mode(master_mode), .tx_one(tx_one),
    .tx_rstart(tx_rstart), .tx_stop(tx_stop), .bus_timeout(bus_timeout),
    .start_seen(start_seen), .stop_seen(stop_seen), .bus_busy(bus_busy),
    .arb_lost(arb_lost), .arb_case(arb_case)
  );

  always @(negedge clk) if (rst_n) begin
    if (start_seen) n_start++;
    if (stop_seen) n_stop++;
    if (arb_lost) begin n_arb++; last_case = arb_case; end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    n_start = 0; n_stop = 0; n_arb = 0; last_case = 2'd0;
  endtask

  task automatic step(logic scl, logic sda);
    @(negedge clk);
    scl_line = scl; sda_line = sda;
    repeat (6) @(posedge clk);
  endtask

  task automatic go_busy();
    step(1, 1); step(1, 0); step(0, 0);
  endtask

  task automatic go_idle();
    step(0, 0); step(1, 0); step(1, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R3 reset busy", bus_busy, 0);
    chk("R1 reset pulses", n_start + n_stop + n_arb, 0);

    // R1 R3: start
    clr(); go_busy(); @(negedge clk);
    chk("R1 start count", n_start, 1);
    chk("R3 busy after start", bus_busy, 1);
    // R2 R3: stop
    clr(); go_idle(); @(negedge clk);
    chk("R2 stop count", n_stop, 1);
    chk("R2 no start at stop", n_start, 0);
    chk("R3 idle after stop", bus_busy, 0);

    // R5 R11 R9: data bit sweep sent x other x active, then rstart variant
    go_busy();
    for (int i = 0; i < 16; i++) begin
      logic snt, oth, act, rs;
      snt = i[0]; oth = i[1]; act = i[2]; rs = i[3];
      @(negedge clk);
      tx_one = snt & ~rs; tx_rstart = rs & snt; tx_active = act; master_mode = 1'b0;
      clr();
      step(0, snt & oth); step(1, snt & oth);
      @(negedge clk); tx_rstart = 1'b0;
      step(0, snt & oth);
      chk("R5 R11 R9 data loss", n_arb, int'(act & snt & ~oth));
      if (act & snt & ~oth) chk("R10 R5 code", last_case, 0);
    end

    // R6 R9: start collision, sweep active x master
    for (int i = 0; i < 4; i++) begin
      logic act, mst;
      act = i[0]; mst = i[1];
      @(negedge clk);
      tx_one = 1'b1; tx_rstart = 1'b0; tx_active = act; master_mode = mst;
      clr();
      step(0, 1); step(1, 1); step(1, 0); step(0, 0);
      chk("R6 start seen", n_start, 1);
      chk("R6 R9 start loss", n_arb, int'(act));
      if (act) chk("R10 R6 code", last_case, 1);
    end

    // R7 R9: clock stolen during repeated start setup
    for (int i = 0; i < 4; i++) begin
      logic act, mst;
      act = i[0]; mst = i[1];
      @(negedge clk);
      tx_one = 1'b0; tx_rstart = 1'b1; tx_active = act; master_mode = mst;
      clr();
      step(0, 1); step(1, 1); step(0, 1);
      chk("R7 R9 clock stolen loss", n_arb, int'(act & mst));
      if (act & mst) chk("R10 R7 code", last_case, 2);
    end

    // R8 R9: stop blocked
    for (int i = 0; i < 4; i++) begin
      logic act, mst;
      act = i[0]; mst = i[1];
      @(negedge clk);
      tx_one = 1'b0; tx_rstart = 1'b0; tx_stop = 1'b1; tx_active = act; master_mode = mst;
      clr();
      step(0, 0); step(1, 0); step(0, 0);
      chk("R8 R9 stop blocked loss", n_arb, int'(act & mst));
      if (act & mst) chk("R10 R8 code", last_case, 3);
      chk("R8 no stop seen", n_stop, 0);
    end

    // R4: time-out
    @(negedge clk); tx_stop = 1'b0; tx_active = 1'b0; master_mode = 1'b0;
    chk("R4 busy before timeout", bus_busy, 1);
    clr();
    @(negedge clk) bus_timeout = 1'b1;
    @(negedge clk) bus_timeout = 1'b0;
    repeat (2) @(negedge clk);
    chk("R4 busy cleared", bus_busy, 0);
    chk("R4 no stop pulse", n_stop, 0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule